// File: doc/BRIEF.md
# Three-Phase Sine Code Sequencer

This block produces three 8-bit sine code streams spaced a third of a cycle apart and loads them into a four-channel latched converter. It drives an address, data and active-low write strobe bus. One sine table is built inside the block when it is elaborated. Three indices read that table, each offset from a shared base index. At every step the block sends three strobed writes, one to each output channel. When it starts, it sends one extra write to the fourth channel, which holds a reference code common to all outputs.

Software sets `enable`, the step divider and the reference code. A timer then advances the base index once per divider period. A full sweep of the base index produces one output period, with 256 steps of about 1.4 degrees each. A single-cycle marker is issued each time the base index wraps back to zero. When `enable` is dropped, any write already started is completed and the bus then goes quiet. Enabling the block again starts a fresh sequence.

Top module: `tri_phase_seq`

## Requirements
- R1: While reset is held and after it is released with `enable` low, `wr_n` is 1, `wrap_pulse` is 0, and `dac_addr` and `dac_data` are 0.
- R2: Channel addresses on `dac_addr` are fixed as follows: output channels 0, 1 and 2 take the leading, middle and lagging phases, and address 3 is the reference channel.
- R3: After `enable` rises, the first write goes to address 3 and carries `ref_code`, before any sample write.
- R4: Each step writes addresses 0, 1 and 2 in that order. The data is table[b], table[(b+85) mod 256] and table[(b+171) mod 256], where b is the base index.
- R5: The table entry for index i is round(128 + 127·sin(2πi/256)), in offset binary, so every entry lies between 1 and 255.
- R6: The base index is 0 for the first step after every enable and increases by one per step, modulo 256.
- R7: Each write drives `wr_n` low for exactly STROBE_LEN clocks. Address and data stay constant from the falling edge through the first clock after `wr_n` returns high.
- R8: The falling edges of successive address-0 writes are `step_div` clocks apart. A `step_div` below MIN_DIV = 3·(STROBE_LEN+3)+2 is treated as MIN_DIV.
- R9: `wrap_pulse` is high for exactly one clock, right after the address-2 write for base index 255 completes. It is therefore seen once every 256 steps.
- R10: When `enable` is low, a write already in progress completes, no new falling edge of `wr_n` occurs, and `wr_n` stays high.
- R11: Re-enabling after a stop repeats the reference write and restarts the base index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request |
| step_div | input | DIV_W | Clocks per table step |
| ref_code | input | DATA_W | Code written to the reference channel |
| dac_addr | output | ADDR_W | Converter channel select |
| dac_data | output | DATA_W | Converter data |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| wrap_pulse | output | 1 | One-clock marker at base index wrap |

## Verification
The assertions assume that `step_div` and `ref_code` do not change while the block is enabled. They also assume that the bus is observed only through its own strobe, so address stability is required only around the low phase of the strobe. The stimulus changes the divider and the reference code only at the clock before `enable` rises. It drops `enable` only while a write strobe is low, which exercises the completion path. One run sets a divider below the minimum and runs for more than 256 steps, which covers both the clamp and the wrap marker.

// File: rtl/tri_phase_pkg.sv
package tri_phase_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_BUSY,
    SQ_WAIT,
    SQ_FETCH
  } seq_state_t;

  typedef enum logic [1:0] {
    WB_IDLE,
    WB_LOW,
    WB_HOLD
  } wbus_state_t;

  // channel numbering decoded by the converter
  localparam int CH_LEAD = 0;
  localparam int CH_MID  = 1;
  localparam int CH_LAG  = 2;
  localparam int CH_REF  = 3;

  localparam real TWO_PI = 6.283185307179586;
  localparam real HALF_TURN = 3.141592653589793;

  // odd power series, argument folded into [-pi, pi]
  function automatic real series_sin(input real x_in);
    real x;
    real term;
    real acc;
    x = x_in;
    if (x > HALF_TURN) x = x - TWO_PI;
    term = x;
    acc  = x;
    for (int k = 1; k <= 12; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic int sine_entry(input int idx, input int depth,
                                    input int mid, input int amp);
    real v;
    v = real'(mid) + real'(amp) * series_sin(TWO_PI * real'(idx) / real'(depth));
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int AMP    = 127
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import tri_phase_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int MID   = 1 << (DATA_W - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(sine_entry(i, DEPTH, MID, AMP));
    end
  end

  // registered read, one clock of latency
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] cnt;

  always_comb begin
    if (div_in < DIV_W'(MIN_DIV)) period = DIV_W'(MIN_DIV);
    else                          period = div_in;
  end

  assign tick = run && (cnt >= period - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt >= period - DIV_W'(1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/bus_writer.sv
module bus_writer #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int STROBE_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              ready,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_wr_n
);
  import tri_phase_pkg::*;

  localparam int CNT_W = $clog2(STROBE_LEN + 1);

  wbus_state_t      state;
  logic [CNT_W-1:0] low_cnt;

  assign ready = (state == WB_IDLE);
  assign done  = (state == WB_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WB_IDLE;
      low_cnt  <= '0;
      bus_addr <= '0;
      bus_data <= '0;
      bus_wr_n <= 1'b1;
    end else begin
      unique case (state)
        WB_IDLE: begin
          if (req) begin
            bus_addr <= req_addr;
            bus_data <= req_data;
            bus_wr_n <= 1'b0;
            low_cnt  <= CNT_W'(STROBE_LEN - 1);
            state    <= WB_LOW;
          end
        end
        WB_LOW: begin
          if (low_cnt == '0) begin
            bus_wr_n <= 1'b1;
            state    <= WB_HOLD;
          end else begin
            low_cnt <= low_cnt - CNT_W'(1);
          end
        end
        WB_HOLD: state <= WB_IDLE;
        default: state <= WB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tri_phase_seq.sv
module tri_phase_seq #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int IDX_W      = 8,
  parameter int DIV_W      = 16,
  parameter int STROBE_LEN = 2,
  parameter int AMP        = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  step_div,
  input  logic [DATA_W-1:0] ref_code,
  output logic [ADDR_W-1:0] dac_addr,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_wr_n,
  output logic              wrap_pulse
);
  import tri_phase_pkg::*;

  localparam int DEPTH   = 1 << IDX_W;
  localparam int PH_MID  = (DEPTH + 1) / 3;
  localparam int PH_LAG  = (2 * DEPTH + 1) / 3;
  localparam int MIN_DIV = 3 * (STROBE_LEN + 3) + 2;
  localparam int NPHASE  = 3;

  seq_state_t        state;
  logic [ADDR_W-1:0] ch;
  logic [IDX_W-1:0]  base;
  logic              wrap_q;

  logic [IDX_W-1:0]  offs [NPHASE];
  logic [IDX_W-1:0]  rom_addr;
  logic [DATA_W-1:0] rom_q;
  logic              tick;
  logic              wr_req;
  logic              wr_ready;
  logic              wr_done;
  logic [DATA_W-1:0] wr_data;

  // phase offsets as fractions of the table length
  for (genvar p = 0; p < NPHASE; p++) begin : g_offs
    localparam int OFS = (p == 0) ? 0 : ((p == 1) ? PH_MID : PH_LAG);
    assign offs[p] = IDX_W'(OFS);
  end

  always_comb begin
    unique case (int'(ch))
      CH_MID:  rom_addr = base + offs[1];
      CH_LAG:  rom_addr = base + offs[2];
      default: rom_addr = base + offs[0];
    endcase
  end

  sine_rom #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .AMP   (AMP)
  ) rom_i (
    .clk    (clk),
    .rd_addr(rom_addr),
    .rd_data(rom_q)
  );

  step_timer #(
    .DIV_W  (DIV_W),
    .MIN_DIV(MIN_DIV)
  ) timer_i (
    .clk   (clk),
    .rst   (rst),
    .run   (state != SQ_IDLE),
    .div_in(step_div),
    .tick  (tick)
  );

  assign wr_data = (ch == ADDR_W'(CH_REF)) ? ref_code : rom_q;
  assign wr_req  = (state == SQ_ISSUE) && enable && wr_ready;

  bus_writer #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STROBE_LEN(STROBE_LEN)
  ) wbus_i (
    .clk     (clk),
    .rst     (rst),
    .req     (wr_req),
    .req_addr(ch),
    .req_data(wr_data),
    .ready   (wr_ready),
    .done    (wr_done),
    .bus_addr(dac_addr),
    .bus_data(dac_data),
    .bus_wr_n(dac_wr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      ch     <= ADDR_W'(CH_LEAD);
      base   <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (enable) begin
            state <= SQ_ISSUE;
            ch    <= ADDR_W'(CH_REF);
            base  <= '0;
          end
        end
        SQ_ISSUE: begin
          if (!enable)       state <= SQ_IDLE;
          else if (wr_ready) state <= SQ_BUSY;
        end
        SQ_BUSY: begin
          if (wr_done) begin
            if (!enable) begin
              state <= SQ_IDLE;
            end else if (ch == ADDR_W'(CH_REF)) begin
              state <= SQ_WAIT;
              ch    <= ADDR_W'(CH_LEAD);
            end else if (ch == ADDR_W'(CH_LAG)) begin
              state  <= SQ_WAIT;
              ch     <= ADDR_W'(CH_LEAD);
              base   <= base + IDX_W'(1);
              wrap_q <= (base == IDX_W'(DEPTH - 1));
            end else begin
              state <= SQ_FETCH;
              ch    <= ch + ADDR_W'(1);
            end
          end
        end
        SQ_WAIT: begin
          if (!enable)   state <= SQ_IDLE;
          else if (tick) state <= SQ_FETCH;
        end
        SQ_FETCH: begin
          if (!enable) state <= SQ_IDLE;
          else         state <= SQ_ISSUE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign wrap_pulse = wrap_q;

endmodule

// File: rtl/tri_phase_seq_chk.sv
module tri_phase_seq_chk #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int STROBE_LEN = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [ADDR_W-1:0] dac_addr,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_wr_n,
  input logic              wrap_pulse
);
  logic [15:0] low_seen;

  always_ff @(posedge clk) begin
    if (rst || dac_wr_n) low_seen <= '0;
    else                 low_seen <= low_seen + 16'd1;
  end

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_wr_n) |-> (low_seen == 16'(STROBE_LEN)));

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |=> ($stable(dac_addr) && $stable(dac_data)));

  // R9
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse);

  // R9
  wrap_after_c_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (dac_wr_n && dac_addr == ADDR_W'(2)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && dac_wr_n) |=> dac_wr_n);

endmodule

bind tri_phase_seq tri_phase_seq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .STROBE_LEN(STROBE_LEN)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .dac_addr  (dac_addr),
  .dac_data  (dac_data),
  .dac_wr_n  (dac_wr_n),
  .wrap_pulse(wrap_pulse)
);

// File: tb/tri_phase_seq_tb_top.sv
module tri_phase_seq_tb_top;
  localparam int STROBE_LEN = 2;
  localparam int MIN_DIV    = 3 * (STROBE_LEN + 3) + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] step_div = 16'd40;
  logic [7:0]  ref_code = 8'd0;
  logic [1:0]  dac_addr;
  logic [7:0]  dac_data;
  logic        dac_wr_n;
  logic        wrap_pulse;

  tri_phase_seq #(.STROBE_LEN(STROBE_LEN)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .step_div  (step_div),
    .ref_code  (ref_code),
    .dac_addr  (dac_addr),
    .dac_data  (dac_data),
    .dac_wr_n  (dac_wr_n),
    .wrap_pulse(wrap_pulse)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done_flag = 1'b0;

  logic [9:0] exp_q[$];
  int  exp_spacing = 0;
  bit  first_a = 1'b1;
  int  c_count = 0;
  int  wraps = 0;
  int  phase = 0;
  longint cyc = 0;
  longint last_a = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int model_sine(input int i);
    real v;
    v = 128.0 + 127.0 * $sin(2.0 * 3.141592653589793 * real'(i) / 256.0);
    return $rtoi(v + 0.5);
  endfunction

  // monitor
  logic       prev_wr = 1'b1;
  logic       prev_wrap = 1'b0;
  logic [1:0] cap_a;
  logic [7:0] cap_d;
  int         low_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_wr && !dac_wr_n) begin
        cap_a = dac_addr;
        cap_d = dac_data;
        low_n = 1;
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected write addr", int'(dac_addr), -1);
        if (dac_addr == 2'd0) begin
          if (!first_a) check(cyc - last_a == longint'(exp_spacing), "R8 step spacing",
                              int'(cyc - last_a), exp_spacing);
          first_a = 1'b0;
          last_a  = cyc;
        end
      end else if (!prev_wr && !dac_wr_n) begin
        low_n++;
        if (dac_addr != cap_a || dac_data != cap_d)
          check(1'b0, "R7 bus moved during strobe", int'(dac_data), int'(cap_d));
      end else if (!prev_wr && dac_wr_n) begin
        check(low_n == STROBE_LEN, "R7 strobe width", low_n, STROBE_LEN);
        check(dac_addr == cap_a && dac_data == cap_d, "R7 hold after strobe",
              int'(dac_data), int'(cap_d));
        if (exp_q.size() > 0) begin
          logic [9:0] e;
          e = exp_q.pop_front();
          if (e[9:8] == 2'd3) begin
            check(dac_addr == 2'd3, "R2 R3 R11 reference address", int'(dac_addr), 3);
            check(dac_data == e[7:0], "R3 R11 reference data", int'(dac_data), int'(e[7:0]));
          end else begin
            check(dac_addr == e[9:8], "R2 R4 channel order", int'(dac_addr), int'(e[9:8]));
            check(dac_data == e[7:0], "R4 R5 R6 sample data", int'(dac_data), int'(e[7:0]));
          end
        end
        if (dac_addr == 2'd2) c_count++;
      end
      if (wrap_pulse) begin
        check(c_count > 0 && (c_count % 256) == 0, "R9 wrap position", c_count, 256);
        check(!prev_wrap, "R9 wrap width", 2, 1);
        wraps++;
      end
      prev_wr   = dac_wr_n;
      prev_wrap = wrap_pulse;
    end
  end

  // driver
  task automatic run_phase(input logic [7:0] refv, input int div, input int nsteps,
                           input int spacing);
    @(negedge clk);
    step_div    = 16'(div);
    ref_code    = refv;
    exp_spacing = spacing;
    first_a     = 1'b1;
    c_count     = 0;
    wraps       = 0;
    phase++;
    exp_q.push_back({2'd3, refv});
    for (int s = 0; s < nsteps; s++) begin
      exp_q.push_back({2'd0, 8'(model_sine(s % 256))});
      exp_q.push_back({2'd1, 8'(model_sine((s + 85) % 256))});
      exp_q.push_back({2'd2, 8'(model_sine((s + 171) % 256))});
    end
    enable = 1'b1;
    while (exp_q.size() > 2) @(negedge clk);
    while (dac_wr_n) @(negedge clk);
    enable = 1'b0;
    repeat (60) @(negedge clk);
    // R10: middle write finished, lagging write of last step never issued
    check(exp_q.size() == 1, "R10 writes after stop", exp_q.size(), 1);
    check(dac_wr_n == 1'b1, "R10 strobe idle", int'(dac_wr_n), 1);
    exp_q.delete();
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(dac_wr_n == 1'b1 && wrap_pulse == 1'b0, "R1 reset outputs", int'(dac_wr_n), 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 after reset, still disabled
    check(dac_wr_n == 1'b1, "R1 strobe high", int'(dac_wr_n), 1);
    check(dac_addr == 2'd0 && dac_data == 8'd0, "R1 bus zero", int'(dac_data), 0);
    check(wrap_pulse == 1'b0, "R1 no wrap", int'(wrap_pulse), 0);

    run_phase(8'hA5, 40, 6, 40);
    // R8 clamp and R9 wrap across a full sweep; R11 restart
    run_phase(8'h3C, 5, 258, MIN_DIV);
    check(wraps == 1, "R9 wrap count", wraps, 1);
    run_phase(8'h80, 23, 4, 23);
    check(wraps == 0, "R6 R9 no early wrap", wraps, 0);
    finish_up();
  end

endmodule